// File: doc/BRIEF.md
# Circular Trace Buffer Write Controller

This block steers fixed-size trace packets into a circular region of on-chip SRAM. Software programs a control word holding a size mask, trigger enables, two privilege bits, a halt request bit and the main enable. Software can also seed a position word holding the packet write pointer and a sticky wrap flag. While tracing is enabled, each offered packet is accepted, written through a simple write port with a completion acknowledge, and the pointer then steps by one 8-byte packet.

The size mask picks the buffer length at run time: the buffer is 2^(mask+4) bytes, which is 2^(mask+1) packets. When the pointer steps past the end of that region, only the pointer bits covered by the mask return to zero and the bits above them are held. The buffer can therefore sit at any address that is a multiple of its own size. External start and stop triggers switch tracing on and off. A stop that arrives while a packet write is outstanding takes effect only after that write completes.

A privilege attribute on the register bus can lock the registers against user-mode writes. A second bit makes SRAM reads by user-mode code return zero and blocks their writes. A debug halt request output follows the halt bit, gated by a debug-enable input.

Top module: `tracebuf_writer`

## Requirements
- R1: After reset the control word reads 0x0000_0080, the position word reads 0, `mem_we` is 0 and `halt_req` is 0.
- R2: Control word layout: size mask in bits 4:0, start-trigger enable at bit 5, stop-trigger enable at bit 6, register write lock at bit 7, SRAM user lock at bit 8, halt bit at bit 9, trace enable at bit 31, other bits read 0. The control word is selected by `reg_addr`=0 and the position word by `reg_addr`=1. Position word layout: pointer in bits AW-1:3, wrap flag at bit 2, other bits read 0.
- R3: When the enable bit is 1 and no write is outstanding, `pkt_ready` is 1. A packet taken with `pkt_valid` and `pkt_ready` both high drives `mem_we`=1 from the next cycle, with `mem_addr` = pointer*8 and `mem_wdata` = the packet. Both are held until the cycle in which `mem_ack` is 1. One cycle after that cycle, `mem_we` is 0 and the pointer has advanced.
- R4: On an advance, with m the effective mask, if pointer bits m:0 are all ones, those bits become 0, the bits above them are unchanged and the wrap flag becomes 1. Otherwise the pointer increments by 1. The wrap flag stays set until the position word is written.
- R5: A mask value above AW-4 acts as AW-4, so the whole pointer field takes part in wrapping.
- R6: When the start-trigger enable is 1 and `trig_start` is high, the enable bit reads 1 one cycle later. When the start-trigger enable is 0, `trig_start` has no effect.
- R7: When the stop-trigger enable is 1 and `trig_stop` is high with no write outstanding, the enable bit reads 0 one cycle later. If a write is outstanding, the enable bit stays 1 until the cycle after `mem_ack`, and no new packet is accepted in between.
- R8: When both triggers are active in the same cycle, the stop wins and the enable bit reads 0.
- R9: Bit 1 of `reg_prot` marks a privileged access. When the register write lock is 1, user-mode writes change no register and privileged writes do. When the lock is 0, user-mode writes take effect.
- R10: When the SRAM user lock is 1, a user-mode SRAM access gives `sb_mem_en`=0, `sb_mem_we`=0 and `sb_rdata`=0. Otherwise the access passes through, with `sb_rdata` equal to `sb_mem_rdata`.
- R11: `halt_req` is 1 exactly when the halt bit is 1 and `dbg_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | Register access is a write |
| reg_addr | input | 1 | 0 selects the control word, 1 selects the position word |
| reg_prot | input | 4 | Bus protection attribute; bit 1 means privileged |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| trig_start | input | 1 | External start trigger |
| trig_stop | input | 1 | External stop trigger |
| dbg_en | input | 1 | Debug enable that gates the halt request |
| halt_req | output | 1 | Debug halt request |
| pkt_valid | input | 1 | Trace packet offered |
| pkt_data | input | DW | Trace packet contents |
| pkt_ready | output | 1 | Packet accepted this cycle if valid |
| mem_we | output | 1 | SRAM packet write request, held until acknowledged |
| mem_addr | output | AW | SRAM byte address of the packet |
| mem_wdata | output | DW | Packet data to write |
| mem_ack | input | 1 | SRAM write completion |
| sb_sel | input | 1 | Bus access to the SRAM |
| sb_wr | input | 1 | SRAM bus access is a write |
| sb_prot | input | 4 | SRAM bus protection attribute; bit 1 means privileged |
| sb_mem_rdata | input | 32 | Read data returned by the SRAM |
| sb_mem_en | output | 1 | SRAM access allowed through |
| sb_mem_we | output | 1 | SRAM write allowed through |
| sb_rdata | output | 32 | Filtered SRAM read data |

## Verification
The bench targets the wrap boundary at the smallest mask, at random masks and at an oversized mask. A design that cleared the wrong bits there would lose the buffer's base address or run past the region, and one that mishandled the clamp would wrap at the wrong length. It puts a stop trigger in the middle of an outstanding write: a design that dropped the enable at once would cut the write short or accept another packet. It also drives both triggers together and sends user-mode register and SRAM accesses under each lock setting. A design that got these wrong would leave tracing on, or would let locked registers change or SRAM data leak.

// File: rtl/tbw_pkg.sv
// Shared types and constants for the circular trace buffer writer.
// Assumes a 32-bit register bus and 8-byte packets.
package tbw_pkg;
    localparam int REG_W      = 32;
    localparam int MASK_W     = 5;
    localparam int PKT_SHIFT  = 3;   // log2 of the packet size in bytes
    localparam int PRIV_BIT   = 1;   // protection bit marking privileged access

    localparam int B_START_EN = 5;
    localparam int B_STOP_EN  = 6;
    localparam int B_WLOCK    = 7;
    localparam int B_RLOCK    = 8;
    localparam int B_HALT     = 9;
    localparam int B_EN       = 31;

    typedef struct packed {
        logic              en;
        logic              halt;
        logic              rlock;
        logic              wlock;
        logic              stop_en;
        logic              start_en;
        logic [MASK_W-1:0] mask;
    } ctrl_t;

    // Places the control fields at their register bit positions.
    function automatic logic [REG_W-1:0] ctrl_pack(ctrl_t c);
        logic [REG_W-1:0] w;
        w               = '0;
        w[MASK_W-1:0]   = c.mask;
        w[B_START_EN]   = c.start_en;
        w[B_STOP_EN]    = c.stop_en;
        w[B_WLOCK]      = c.wlock;
        w[B_RLOCK]      = c.rlock;
        w[B_HALT]       = c.halt;
        w[B_EN]         = c.en;
        return w;
    endfunction
endpackage

// File: rtl/tbw_ctrl_regs.sv
// Control word storage and trace enable sequencing.
// Assumes the write strobe is already privilege-qualified. A stop trigger
// seen during an outstanding packet write is held until that write is done.
module tbw_ctrl_regs
    import tbw_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_ctrl,
    input  ctrl_t wr_fields,
    input  logic  trig_start,
    input  logic  trig_stop,
    input  logic  busy,
    input  logic  done,
    output ctrl_t ctrl,
    output logic  accept_ok
);
    logic stop_pend, start_hit, stop_now, stop_apply, en_next;

    // Decide the next enable: software write, then start, then stop (stop wins).
    always_comb begin
        start_hit  = ctrl.start_en & trig_start;
        stop_now   = (ctrl.stop_en & trig_stop) | stop_pend;
        stop_apply = stop_now & (~busy | done);
        en_next    = wr_ctrl ? wr_fields.en : ctrl.en;
        if (start_hit)  en_next = 1'b1;
        if (stop_apply) en_next = 1'b0;
        accept_ok  = ctrl.en & ~stop_now;
    end

    // Register the control fields and the deferred stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl       <= '0;
            ctrl.wlock <= 1'b1;
            stop_pend  <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl <= wr_fields;
            ctrl.en   <= en_next;
            stop_pend <= stop_now & ~stop_apply;
        end
    end
endmodule

// File: rtl/tbw_ptr.sv
// Write pointer and sticky wrap flag with a run-time power-of-two wrap point.
// Assumes the pointer counts packets; only bits at and below the clamped
// mask take part in the increment, higher bits hold the buffer base.
module tbw_ptr
    import tbw_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [MASK_W-1:0]     mask,
    input  logic                  wr_pos,
    input  logic [AW-1:2]         wdata,
    input  logic                  advance,
    output logic [AW-PKT_SHIFT-1:0] ptr,
    output logic                  wrap
);
    localparam int PW   = AW - PKT_SHIFT;
    localparam int MMAX = AW - 4;

    logic [MASK_W-1:0] mask_eff;
    logic [PW-1:0]     low_mask, ptr_next;
    logic              at_end;

    // Clamp the mask to the widest legal value.
    always_comb mask_eff = (mask > MASK_W'(MMAX)) ? MASK_W'(MMAX) : mask;

    // One mask bit per pointer bit: set when that bit lies inside the buffer.
    for (genvar g = 0; g < PW; g++) begin : g_low
        assign low_mask[g] = (MASK_W'(g) <= mask_eff);
    end

    // Compute the stepped pointer, clearing only the in-buffer bits on wrap.
    always_comb begin
        at_end   = ((ptr & low_mask) == low_mask);
        ptr_next = at_end ? (ptr & ~low_mask) : (ptr + 1'b1);
    end

    // Load from software or step after a completed packet write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            wrap <= 1'b0;
        end else if (wr_pos) begin
            ptr  <= wdata[AW-1:PKT_SHIFT];
            wrap <= wdata[2];
        end else if (advance) begin
            ptr <= ptr_next;
            if (at_end) wrap <= 1'b1;
        end
    end
endmodule

// File: rtl/tbw_wport.sv
// Packet write port: captures one packet and its address, holds the SRAM
// write request until acknowledged. Assumes one write outstanding at a time.
module tbw_wport
    import tbw_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    accept_ok,
    input  logic                    pkt_valid,
    input  logic [DW-1:0]           pkt_data,
    input  logic [AW-PKT_SHIFT-1:0] ptr,
    input  logic                    mem_ack,
    output logic                    pkt_ready,
    output logic                    mem_we,
    output logic [AW-1:0]           mem_addr,
    output logic [DW-1:0]           mem_wdata,
    output logic                    busy,
    output logic                    done
);
    // Handshake terms toward the packet source and the pointer.
    always_comb begin
        pkt_ready = accept_ok & ~busy;
        done      = busy & mem_ack;
        mem_we    = busy;
    end

    // Capture on accept, release on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (pkt_valid && pkt_ready) begin
            busy      <= 1'b1;
            mem_addr  <= {ptr, {PKT_SHIFT{1'b0}}};
            mem_wdata <= pkt_data;
        end else if (done) begin
            busy <= 1'b0;
        end
    end
endmodule

// File: rtl/tbw_sram_gate.sv
// Filters bus accesses to the trace SRAM: with the lock set, user-mode
// accesses are blocked and read back as zero. Purely combinational.
module tbw_sram_gate
    import tbw_pkg::*;
(
    input  logic             rlock,
    input  logic             sb_sel,
    input  logic             sb_wr,
    input  logic             sb_priv,
    input  logic [REG_W-1:0] sb_mem_rdata,
    output logic             sb_mem_en,
    output logic             sb_mem_we,
    output logic [REG_W-1:0] sb_rdata
);
    logic allow;

    // Pass privileged accesses always, user accesses only when unlocked.
    always_comb begin
        allow     = ~rlock | sb_priv;
        sb_mem_en = sb_sel & allow;
        sb_mem_we = sb_sel & sb_wr & allow;
        sb_rdata  = allow ? sb_mem_rdata : '0;
    end
endmodule

// File: rtl/tracebuf_writer.sv
// Circular trace buffer write controller: register access with write lock,
// pointer and wrap logic, trigger sequencing, SRAM access filter and halt
// request. Assumes register reads are combinational on reg_addr.
module tracebuf_writer
    import tbw_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [3:0]       reg_prot,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             trig_start,
    input  logic             trig_stop,
    input  logic             dbg_en,
    output logic             halt_req,
    input  logic             pkt_valid,
    input  logic [DW-1:0]    pkt_data,
    output logic             pkt_ready,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic             sb_sel,
    input  logic             sb_wr,
    input  logic [3:0]       sb_prot,
    input  logic [REG_W-1:0] sb_mem_rdata,
    output logic             sb_mem_en,
    output logic             sb_mem_we,
    output logic [REG_W-1:0] sb_rdata
);
    localparam int PW = AW - PKT_SHIFT;

    ctrl_t            ctrl, wr_fields;
    logic [REG_W-1:0] ctrl_word, pos_word;
    logic [PW-1:0]    pos_ptr;
    logic             pos_wrap, wr_ok, wr_ctrl, wr_pos;
    logic             accept_ok, busy, done;
    logic             unused_bits;

    // Qualify register writes by the lock and the privilege attribute.
    always_comb begin
        wr_ok   = reg_sel & reg_wr & (~ctrl.wlock | reg_prot[PRIV_BIT]);
        wr_ctrl = wr_ok & ~reg_addr;
        wr_pos  = wr_ok & reg_addr;
    end

    // Pick the control fields out of the write data.
    always_comb begin
        wr_fields.mask     = reg_wdata[MASK_W-1:0];
        wr_fields.start_en = reg_wdata[B_START_EN];
        wr_fields.stop_en  = reg_wdata[B_STOP_EN];
        wr_fields.wlock    = reg_wdata[B_WLOCK];
        wr_fields.rlock    = reg_wdata[B_RLOCK];
        wr_fields.halt     = reg_wdata[B_HALT];
        wr_fields.en       = reg_wdata[B_EN];
    end

    // Read mux for the two register words.
    always_comb begin
        ctrl_word            = ctrl_pack(ctrl);
        pos_word             = '0;
        pos_word[AW-1:0]     = {pos_ptr, pos_wrap, 2'b00};
        reg_rdata            = reg_addr ? pos_word : ctrl_word;
        halt_req             = ctrl.halt & dbg_en;
    end

    assign unused_bits = ^{reg_wdata[B_EN-1:B_HALT+1], reg_wdata[1:0],
                           reg_wdata[REG_W-1:AW], reg_prot[3:2], reg_prot[0],
                           sb_prot[3:2], sb_prot[0]};

    tbw_ctrl_regs u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .wr_fields  (wr_fields),
        .trig_start (trig_start),
        .trig_stop  (trig_stop),
        .busy       (busy),
        .done       (done),
        .ctrl       (ctrl),
        .accept_ok  (accept_ok)
    );

    tbw_ptr #(.AW(AW)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask    (ctrl.mask),
        .wr_pos  (wr_pos),
        .wdata   (reg_wdata[AW-1:2]),
        .advance (done),
        .ptr     (pos_ptr),
        .wrap    (pos_wrap)
    );

    tbw_wport #(.AW(AW), .DW(DW)) u_wport (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_ok (accept_ok),
        .pkt_valid (pkt_valid),
        .pkt_data  (pkt_data),
        .ptr       (pos_ptr),
        .mem_ack   (mem_ack),
        .pkt_ready (pkt_ready),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .done      (done)
    );

    tbw_sram_gate u_gate (
        .rlock        (ctrl.rlock),
        .sb_sel       (sb_sel),
        .sb_wr        (sb_wr),
        .sb_priv      (sb_prot[PRIV_BIT]),
        .sb_mem_rdata (sb_mem_rdata),
        .sb_mem_en    (sb_mem_en),
        .sb_mem_we    (sb_mem_we),
        .sb_rdata     (sb_rdata)
    );
endmodule

// File: rtl/tracebuf_writer_chk.sv
// Property checker for tracebuf_writer, attached by bind below.
module tracebuf_writer_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_sel,
    input logic          reg_wr,
    input logic          reg_priv,
    input logic [31:0]   ctrl_word,
    input logic          pos_wrap,
    input logic          wr_pos,
    input logic          pkt_valid,
    input logic          pkt_ready,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic          dbg_en,
    input logic          halt_req,
    input logic          sb_sel,
    input logic          sb_priv,
    input logic          sb_mem_en,
    input logic [31:0]   sb_rdata
);
    // R3: an accepted packet raises the write request next cycle
    p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready) |=> mem_we);

    // R3: an unacknowledged write keeps its request and address
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_ack) |=> (mem_we && $stable(mem_addr)));

    // R4: the wrap flag only rises after a completed write or a position load
    p_wrap_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pos_wrap) |-> ($past(mem_we && mem_ack) || $past(wr_pos)));

    // R7: no packet is accepted while tracing is off
    p_no_accept_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_word[31] |-> !pkt_ready);

    // R9: a locked user write leaves the configuration fields unchanged
    p_user_wr_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && !reg_priv && ctrl_word[7]) |=> $stable(ctrl_word[9:0]));

    // R10: locked user SRAM accesses are blocked and read zero
    p_sram_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_sel && ctrl_word[8] && !sb_priv) |-> (!sb_mem_en && sb_rdata == 32'h0));

    // R11: a halt request needs both the halt bit and debug enable
    p_halt_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> (dbg_en && ctrl_word[9]));
endmodule

bind tracebuf_writer tracebuf_writer_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_priv  (reg_prot[1]),
    .ctrl_word (ctrl_word),
    .pos_wrap  (pos_wrap),
    .wr_pos    (wr_pos),
    .pkt_valid (pkt_valid),
    .pkt_ready (pkt_ready),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .dbg_en    (dbg_en),
    .halt_req  (halt_req),
    .sb_sel    (sb_sel),
    .sb_priv   (sb_prot[1]),
    .sb_mem_en (sb_mem_en),
    .sb_rdata  (sb_rdata)
);

// File: tb/tracebuf_writer_test.sv
module tracebuf_writer_test;
    localparam int CLK_P = 10;
    localparam int AW    = 16;
    localparam int DW    = 64;
    localparam int PW    = AW - 3;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          reg_sel = 0, reg_wr = 0, reg_addr = 0;
    logic [3:0]    reg_prot = 0;
    logic [31:0]   reg_wdata = 0, reg_rdata;
    logic          trig_start = 0, trig_stop = 0, dbg_en = 0, halt_req;
    logic          pkt_valid = 0, pkt_ready;
    logic [DW-1:0] pkt_data = 0, mem_wdata;
    logic          mem_we, mem_ack = 0;
    logic [AW-1:0] mem_addr;
    logic          sb_sel = 0, sb_wr = 0;
    logic [3:0]    sb_prot = 0;
    logic [31:0]   sb_mem_rdata = 0, sb_rdata;
    logic          sb_mem_en, sb_mem_we;

    tracebuf_writer #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_prot(reg_prot), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .trig_start(trig_start), .trig_stop(trig_stop),
        .dbg_en(dbg_en), .halt_req(halt_req), .pkt_valid(pkt_valid),
        .pkt_data(pkt_data), .pkt_ready(pkt_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .sb_sel(sb_sel), .sb_wr(sb_wr), .sb_prot(sb_prot),
        .sb_mem_rdata(sb_mem_rdata), .sb_mem_en(sb_mem_en),
        .sb_mem_we(sb_mem_we), .sb_rdata(sb_rdata)
    );

    always #(CLK_P/2) clk = ~clk;

    int total = 0, bad = 0;
    bit finished = 0;
    logic [PW-1:0] m_ptr;
    logic          m_wrap;
    logic [31:0]   v;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Expected pointer step from the wrap rule, with the mask clamped.
    function automatic logic [PW-1:0] model_next(logic [PW-1:0] p, int m, output logic wrapped);
        int mc = (m > PW - 1) ? PW - 1 : m;
        logic [PW-1:0] lm = '0;
        for (int i = 0; i <= mc; i++) lm[i] = 1'b1;
        wrapped = ((p & lm) == lm);
        return wrapped ? (p & ~lm) : (p + 1'b1);
    endfunction

    function automatic logic [31:0] cw(bit en, int mask, bit sten, bit spen, bit halt, bit rl);
        logic [31:0] w = '0;
        w[4:0] = mask[4:0]; w[5] = sten; w[6] = spen; w[7] = 1'b1;
        w[8] = rl; w[9] = halt; w[31] = en;
        return w;
    endfunction

    task automatic wr_reg(bit addr, logic [31:0] d, bit priv);
        @(negedge clk);
        reg_sel = 1; reg_wr = 1; reg_addr = addr; reg_wdata = d;
        reg_prot = priv ? 4'b0010 : 4'b0000;
        @(posedge clk); #1;
        reg_sel = 0; reg_wr = 0;
    endtask

    task automatic rd_reg(bit addr, output logic [31:0] r);
        reg_addr = addr; #1; r = reg_rdata;
    endtask

    task automatic set_pos(logic [PW-1:0] p, logic w);
        wr_reg(1, {16'h0, p, w, 2'b00}, 1);
        m_ptr = p; m_wrap = w;
    endtask

    task automatic pulse(bit st, bit sp);
        @(negedge clk); trig_start = st; trig_stop = sp;
        @(posedge clk); #1; trig_start = 0; trig_stop = 0;
    endtask

    // Send one packet, hold the ack off for dly cycles, check against the model.
    task automatic send(string tag, logic [63:0] d, int dly, int m);
        logic wrp;
        logic [31:0] r;
        @(negedge clk); pkt_valid = 1; pkt_data = d; #1;
        chk({tag, " R3 ready"}, pkt_ready, 1);
        @(posedge clk); #1; pkt_valid = 0;
        chk({tag, " R3 we"}, mem_we, 1);
        chk({tag, " R3 addr"}, mem_addr, {m_ptr, 3'b000});
        chk({tag, " R3 data"}, mem_wdata, d);
        for (int k = 0; k < dly; k++) begin
            @(posedge clk); #1;
            chk({tag, " R3 hold"}, {mem_we, mem_addr}, {1'b1, m_ptr, 3'b000});
        end
        @(negedge clk); mem_ack = 1;
        @(posedge clk); #1; mem_ack = 0;
        chk({tag, " R3 release"}, mem_we, 0);
        m_ptr = model_next(m_ptr, m, wrp);
        if (wrp) m_wrap = 1'b1;
        rd_reg(1, r);
        chk({tag, " R4 position"}, r, {16'h0, m_ptr, m_wrap, 2'b00});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R1 act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd715));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;

        // R1 reset state
        rd_reg(0, v); chk("R1 ctrl", v, 32'h80);
        rd_reg(1, v); chk("R1 pos", v, 0);
        chk("R1 we/halt", {mem_we, halt_req}, 0);

        // R2 field layout
        wr_reg(0, cw(0, 3, 1, 1, 1, 1), 1);
        rd_reg(0, v); chk("R2 ctrl fields", v, 32'h0000_03E3);
        wr_reg(0, 32'hFFFF_FFFF, 1);
        rd_reg(0, v); chk("R2 ctrl all ones", v, 32'h8000_03FF);
        wr_reg(0, cw(0, 0, 0, 0, 0, 0), 1);
        wr_reg(1, 32'hFFFF_FFFF, 1);
        rd_reg(1, v); chk("R2 pos layout", v, 32'h0000_FFFC);
        set_pos(0, 0);

        // R11 halt gating
        wr_reg(0, cw(0, 0, 0, 0, 1, 0), 1); #1;
        chk("R11 halt no dbg", halt_req, 0);
        dbg_en = 1; #1; chk("R11 halt dbg", halt_req, 1);
        wr_reg(0, cw(0, 0, 0, 0, 0, 0), 1);
        chk("R11 halt cleared", halt_req, 0);
        dbg_en = 0;

        // R9 write lock
        wr_reg(0, 32'h0000_0000, 0);
        rd_reg(0, v); chk("R9 user write ignored", v, 32'h80);
        wr_reg(1, 32'h0000_0100, 0);
        rd_reg(1, v); chk("R9 user pos write ignored", v, 0);
        wr_reg(0, 32'h0000_0005, 1);
        rd_reg(0, v); chk("R9 priv write unlock", v, 32'h5);
        wr_reg(0, 32'h0000_0086, 0);
        rd_reg(0, v); chk("R9 user write when unlocked", v, 32'h86);

        // R10 SRAM filter
        wr_reg(0, cw(0, 0, 0, 0, 0, 1), 1);
        sb_sel = 1; sb_wr = 1; sb_prot = 4'b0000; sb_mem_rdata = 32'hDEAD_BEEF; #1;
        chk("R10 locked user", {sb_mem_en, sb_mem_we, sb_rdata}, 0);
        sb_prot = 4'b0010; #1;
        chk("R10 locked priv", {sb_mem_en, sb_mem_we, sb_rdata}, {2'b11, 32'hDEAD_BEEF});
        wr_reg(0, cw(0, 0, 0, 0, 0, 0), 1);
        sb_prot = 4'b0000; sb_wr = 0; #1;
        chk("R10 unlocked user", {sb_mem_en, sb_mem_we, sb_rdata}, {2'b10, 32'hDEAD_BEEF});
        sb_sel = 0;

        // R4 smallest buffer, wrap keeps upper bits, flag sticky
        set_pos(13'h0AA, 0);
        wr_reg(0, cw(1, 0, 0, 0, 0, 0), 1);
        send("mask0 a", 64'h1111, 0, 0);
        send("mask0 b", 64'h2222, 2, 0);
        chk("R4 wrap kept upper", {m_ptr, m_wrap}, {13'h0AA, 1'b1});
        send("mask0 c", 64'h3333, 1, 0);
        set_pos(13'h0AA, 0);
        rd_reg(1, v); chk("R4 wrap cleared by load", v, {16'h0, 13'h0AA, 3'b000});

        // R5 oversized mask clamps to the full pointer
        wr_reg(0, cw(1, 31, 0, 0, 0, 0), 1);
        set_pos(13'h1FFF, 0);
        send("R5 clamp", 64'hCAFE, 0, 31);
        rd_reg(1, v); chk("R5 clamp wrap", v, 32'h0000_0004);

        // R3/R4 random masks, bases and ack delays
        for (int it = 0; it < 40; it++) begin
            int m = $urandom_range(0, 15);
            int n = $urandom_range(1, 6);
            wr_reg(0, cw(1, m, 0, 0, 0, 0), 1);
            set_pos(PW'($urandom), 0);
            for (int k = 0; k < n; k++)
                send("rand", {$urandom, $urandom}, $urandom_range(0, 3), m);
        end

        // R6 start trigger
        wr_reg(0, cw(0, 2, 0, 0, 0, 0), 1);
        pulse(1, 0);
        rd_reg(0, v); chk("R6 start disabled", v[31], 0);
        wr_reg(0, cw(0, 2, 1, 0, 0, 0), 1);
        pulse(1, 0);
        rd_reg(0, v); chk("R6 start enabled", v[31], 1);

        // R7 stop while idle
        wr_reg(0, cw(1, 2, 0, 1, 0, 0), 1);
        pulse(0, 1);
        rd_reg(0, v); chk("R7 idle stop", {v[31], pkt_ready}, 0);

        // R7 stop during an outstanding write
        wr_reg(0, cw(1, 2, 0, 1, 0, 0), 1);
        set_pos(13'h40, 0);
        @(negedge clk); pkt_valid = 1; pkt_data = 64'hABCD;
        @(posedge clk); #1; pkt_valid = 0;
        pulse(0, 1);
        rd_reg(0, v);
        chk("R7 deferred stop", {v[31], mem_we, pkt_ready}, 3'b110);
        @(negedge clk); mem_ack = 1;
        @(posedge clk); #1; mem_ack = 0;
        rd_reg(0, v);
        chk("R7 stop after ack", {v[31], mem_we, pkt_ready}, 3'b000);
        rd_reg(1, v); chk("R7 write completed", v, {16'h0, 13'h41, 3'b000});

        // R8 stop beats start
        wr_reg(0, cw(1, 2, 1, 1, 0, 0), 1);
        pulse(1, 1);
        rd_reg(0, v); chk("R8 both triggers", v[31], 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule